// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block finds and holds the basic frame boundary in a received 2.048 Mbit/s E1 bit stream. One serial bit arrives per asserted bit enable, most significant bit of each timeslot first. A frame is 256 bits: 32 timeslots of 8 bits, repeating every 125 us. Timeslot 0 carries a fixed 7-bit alignment word (0011011) in its bits 2 to 8 on every other frame. The frames between carry a 1 in bit 2 of timeslot 0.

While unaligned, the block tests every bit position against the alignment word. A candidate is accepted in three steps. First the word is found. Next, bit 2 of timeslot 0 in the following frame must be 1. Last, the word must be present again one frame after that check. Once aligned, downstream logic gets a timeslot number and a bit number for every received bit. The block also keeps a saturating count of frames spent unaligned, which a synchronous clear resets.

Top module: `e1_frame_aligner`

## Requirements
- R1: `ts_num` and `bit_num` give the position of the next bit to arrive, as a count 0 to 255 split into timeslot (upper 5 bits) and bit within the timeslot (lower 3 bits). `bit_num` 0 is bit 1, the MSB, which arrives first. Each accepted bit advances the position by one, and it wraps from timeslot 31 bit 7 to timeslot 0 bit 0.
- R2: While unaligned, every accepted bit is tested. The block takes a candidate when the last 7 bits received equal 0011011, oldest first. That bit is then taken as bit 8 of timeslot 0, and the position becomes timeslot 1, bit 0.
- R3: After a candidate, bit 2 (`bit_num` 1) of timeslot 0 in the next frame is checked. If it is 0, the search restarts and the block stays unaligned.
- R4: Alignment is declared only when the alignment word is present again in timeslot 0 of the frame after the R3 check. `out_of_sync` falls right after the accepted bit that completes that word, so the position then reads timeslot 1, bit 0.
- R5: If the word is missing in that confirming frame, the search restarts.
- R6: `out_of_sync` is 1 when unaligned and 0 when aligned. It is 1 after reset.
- R7: While aligned, the word is checked in every other frame. Three consecutive errored words drop alignment and restart the bit-by-bit search. A correct word resets the error run.
- R8: `loss_cnt` increments by one at the last bit of every frame (timeslot 31, bit 7) while the block is unaligned. It does not change while the block is aligned.
- R9: `loss_cnt` saturates at its all-ones value instead of wrapping.
- R10: `cnt_clr` sets `loss_cnt` to 0 on the next clock edge, and it takes priority over an increment.
- R11: With `bit_en` low, the position, the sync state and the search make no progress, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Accept `rx_bit` on this clock edge |
| rx_bit | input | 1 | Serial received data, MSB of each timeslot first |
| cnt_clr | input | 1 | Synchronous clear of the loss counter |
| out_of_sync | output | 1 | 1 while not frame aligned |
| ts_num | output | 5 | Timeslot of the next bit |
| bit_num | output | 3 | Bit within the timeslot of the next bit (0 = MSB) |
| loss_cnt | output | CNT_W | Saturating count of unaligned frames |

## Verification
Every result is registered once, so a result is due on the clock edge that accepts the causing bit. The sync flag and the position change on the edge that takes bit 8 of timeslot 0, and the loss counter on the edge that takes the last bit of a frame. A clear acts on the edge that samples `cnt_clr`. The bench drives each bit for one cycle and then leaves `bit_en` low for one cycle. It reads the outputs on the falling edge after the capturing edge, and it checks the sync flag and position right after the eighth bit of timeslot 0 and the counter right after a frame's last bit.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_NFAS = 2'd1,
    ST_CONF = 2'd2,
    ST_LOCK = 2'd3
  } fa_state_t;

  localparam logic [6:0] ALIGN_WORD = 7'b0011011;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int WIN_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic hit
);
  import e1fa_pkg::*;
  localparam int WORD_W = $bits(ALIGN_WORD);

  logic [WIN_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[WIN_W-2:0], rx_bit};
    hit  = bit_en && (sr_d[WORD_W-1:0] == ALIGN_WORD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '1;
    else if (bit_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/e1fa_position.sv
module e1fa_position #(
  parameter int TS_BITS = 8,
  parameter int NUM_TS  = 32,
  localparam int POS_W  = $clog2(TS_BITS) + $clog2(NUM_TS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             load,
  output logic [POS_W-1:0] pos,
  output logic             word_frame,
  output logic             frame_end
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TS_BITS*NUM_TS - 1);
  localparam logic [POS_W-1:0] LOAD_POS = POS_W'(TS_BITS);

  logic [POS_W-1:0] pos_d;
  logic             wf_d;

  always_comb begin
    frame_end = bit_en && (pos == LAST_POS);
    pos_d     = pos;
    wf_d      = word_frame;
    if (load) begin
      pos_d = LOAD_POS;
      wf_d  = 1'b1;
    end else if (bit_en) begin
      pos_d = pos + 1'b1;
      if (pos == LAST_POS) wf_d = ~word_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      word_frame <= 1'b0;
    end else begin
      pos        <= pos_d;
      word_frame <= wf_d;
    end
  end
endmodule

// File: rtl/e1fa_fsm.sv
module e1fa_fsm #(
  parameter int TS_BITS    = 8,
  parameter int POS_W      = 8,
  parameter int MISS_LIMIT = 3,
  localparam int ERR_W     = $clog2(MISS_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                rx_bit,
  input  logic                hit,
  input  logic [POS_W-1:0]    pos,
  input  logic                word_frame,
  output e1fa_pkg::fa_state_t state,
  output logic                load
);
  import e1fa_pkg::*;
  localparam logic [POS_W-1:0] BIT2_POS = POS_W'(1);
  localparam logic [POS_W-1:0] LAST_TS0 = POS_W'(TS_BITS - 1);
  localparam logic [ERR_W-1:0] ERR_MAX  = ERR_W'(MISS_LIMIT - 1);

  fa_state_t        state_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             at_bit2, at_word_end;

  always_comb begin
    at_bit2     = bit_en && (pos == BIT2_POS) && !word_frame;
    at_word_end = bit_en && (pos == LAST_TS0) && word_frame;
    state_d     = state;
    err_d       = err_q;
    load        = 1'b0;
    unique case (state)
      ST_HUNT: if (hit) begin
        load    = 1'b1;
        state_d = ST_NFAS;
      end
      ST_NFAS: if (at_bit2) state_d = rx_bit ? ST_CONF : ST_HUNT;
      ST_CONF: if (at_word_end) begin
        state_d = hit ? ST_LOCK : ST_HUNT;
        err_d   = '0;
      end
      ST_LOCK: if (at_word_end) begin
        if (hit) begin
          err_d = '0;
        end else if (err_q == ERR_MAX) begin
          err_d   = '0;
          state_d = ST_HUNT;
        end else begin
          err_d = err_q + 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      err_q <= '0;
    end else begin
      state <= state_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/e1fa_loss_cnt.sv
module e1fa_loss_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)                 count_d = '0;
    else if (inc && ~&count) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
  parameter int TS_BITS    = 8,
  parameter int NUM_TS     = 32,
  parameter int MISS_LIMIT = 3,
  parameter int CNT_W      = 16,
  localparam int BIT_W     = $clog2(TS_BITS),
  localparam int TS_W      = $clog2(NUM_TS),
  localparam int POS_W     = BIT_W + TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             cnt_clr,
  output logic             out_of_sync,
  output logic [TS_W-1:0]  ts_num,
  output logic [BIT_W-1:0] bit_num,
  output logic [CNT_W-1:0] loss_cnt
);
  import e1fa_pkg::*;

  logic             hit, load, word_frame, frame_end;
  logic [POS_W-1:0] pos;
  fa_state_t        state;

  e1fa_window #(.WIN_W(TS_BITS)) win_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .hit(hit)
  );

  e1fa_position #(.TS_BITS(TS_BITS), .NUM_TS(NUM_TS)) pos_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
    .pos(pos), .word_frame(word_frame), .frame_end(frame_end)
  );

  e1fa_fsm #(.TS_BITS(TS_BITS), .POS_W(POS_W), .MISS_LIMIT(MISS_LIMIT)) fsm_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .hit(hit),
    .pos(pos), .word_frame(word_frame), .state(state), .load(load)
  );

  e1fa_loss_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .inc(frame_end && (state != ST_LOCK)), .count(loss_cnt)
  );

  assign out_of_sync = (state != ST_LOCK);
  assign ts_num      = pos[POS_W-1:BIT_W];
  assign bit_num     = pos[BIT_W-1:0];
endmodule

// File: rtl/e1fa_chk.sv
module e1fa_chk #(
  parameter int TS_W  = 5,
  parameter int BIT_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             cnt_clr,
  input logic             out_of_sync,
  input logic [TS_W-1:0]  ts_num,
  input logic [BIT_W-1:0] bit_num,
  input logic [CNT_W-1:0] loss_cnt
);
  localparam int POS_W = TS_W + BIT_W;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !out_of_sync) |=> {ts_num, bit_num} == POS_W'($past({ts_num, bit_num}) + 1'b1))
    else $error("p_step_r1");

  p_lock_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_of_sync) |-> (ts_num == TS_W'(1) && bit_num == '0))
    else $error("p_lock_pos_r4");

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(ts_num) && $stable(bit_num) && $stable(out_of_sync)))
    else $error("p_idle_r11");

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (loss_cnt == $past(loss_cnt) || loss_cnt == CNT_W'($past(loss_cnt) + 1'b1)))
    else $error("p_count_step_r8");

  p_locked_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_of_sync && !cnt_clr) |=> $stable(loss_cnt))
    else $error("p_locked_still_r8");

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&loss_cnt && !cnt_clr) |=> &loss_cnt)
    else $error("p_no_wrap_r9");

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> loss_cnt == '0)
    else $error("p_clear_r10");
endmodule

bind e1_frame_aligner e1fa_chk #(.TS_W(TS_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cnt_clr(cnt_clr),
  .out_of_sync(out_of_sync), .ts_num(ts_num), .bit_num(bit_num), .loss_cnt(loss_cnt)
);

// File: tb/e1_frame_aligner_tb_top.sv
module e1_frame_aligner_tb_top;
  localparam int CW = 4;
  localparam logic [7:0] FAS_OK  = 8'h9B; // 1 0011011
  localparam logic [7:0] FAS_BAD = 8'h9A; // 1 0011010
  localparam logic [7:0] NFAS_OK = 8'hDF; // bit2 = 1
  localparam logic [7:0] NFAS_Z  = 8'h9F; // bit2 = 0
  localparam int NV = 28;
  // each entry: {timeslot-0 byte, expected out_of_sync after its 8th bit}
  localparam logic [8:0] VEC [NV] = '{
    {FAS_OK,1'b1}, {NFAS_OK,1'b1}, {FAS_OK,1'b0}, {NFAS_OK,1'b0},
    {FAS_OK,1'b0}, {NFAS_OK,1'b0}, {FAS_BAD,1'b0}, {NFAS_OK,1'b0},
    {FAS_BAD,1'b0}, {NFAS_OK,1'b0}, {FAS_OK,1'b0}, {NFAS_OK,1'b0},
    {FAS_BAD,1'b0}, {NFAS_OK,1'b0}, {FAS_BAD,1'b0}, {NFAS_OK,1'b0},
    {FAS_BAD,1'b1}, {NFAS_OK,1'b1}, {FAS_OK,1'b1}, {NFAS_OK,1'b1},
    {FAS_BAD,1'b1}, {NFAS_OK,1'b1}, {FAS_OK,1'b1}, {NFAS_Z,1'b1},
    {FAS_OK,1'b1}, {NFAS_OK,1'b1}, {FAS_OK,1'b0}, {NFAS_OK,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b1, cnt_clr = 1'b0;
  logic          out_of_sync;
  logic [4:0]    ts_num;
  logic [2:0]    bit_num;
  logic [CW-1:0] loss_cnt;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  e1_frame_aligner #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .cnt_clr(cnt_clr),
    .out_of_sync(out_of_sync), .ts_num(ts_num), .bit_num(bit_num), .loss_cnt(loss_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_payload();
    for (int i = 0; i < 31*8; i++) send_bit(1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 reset out_of_sync", out_of_sync, 1);
    check("R8 reset loss_cnt", loss_cnt, 0);
    check("R1 reset position", {ts_num, bit_num}, 0);
    rst_n = 1'b1;

    for (int f = 0; f < NV; f++) begin
      send_byte(VEC[f][8:1]);
      // R2 R3 R4 R5 R7: sync flag right after bit 8 of timeslot 0
      check($sformatf("R4/R7 frame %0d out_of_sync", f), out_of_sync, VEC[f][0]);
      if (!VEC[f][0]) check($sformatf("R1 frame %0d position", f), {ts_num, bit_num}, 8);
      send_payload();
    end
    // R8: frames 0,1 and 16..25 were unaligned at their last bit
    check("R8 loss count after table", loss_cnt, 12);
    check("R1 wrap to frame start", {ts_num, bit_num}, 0);

    // R11: toggling data with bit_en low changes nothing
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rx_bit = i[0];
    end
    check("R11 position held", {ts_num, bit_num}, 0);
    check("R11 sync held", out_of_sync, 0);

    // R10: clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    check("R10 clear", loss_cnt, 0);

    // R7: all-ones frames, word missing in frames 28, 30, 32
    for (int f = 28; f < 32; f++) begin send_byte(8'hFF); send_payload(); end
    check("R7 two misses keep sync", out_of_sync, 0);
    check("R8 no count while aligned", loss_cnt, 0);
    send_byte(8'hFF);
    check("R7 third miss drops sync", out_of_sync, 1);
    send_payload();
    check("R8 first unaligned frame", loss_cnt, 1);
    for (int f = 33; f < 48; f++) begin send_byte(8'hFF); send_payload(); end
    check("R9 saturation", loss_cnt, 15);
    send_byte(8'hFF); send_payload();
    check("R9 stays saturated", loss_cnt, 15);

    // R10: clear has priority over an increment on the last bit of a frame
    send_byte(8'hFF);
    for (int i = 0; i < 31*8 - 1; i++) send_bit(1'b1);
    @(negedge clk); rx_bit = 1'b1; bit_en = 1'b1; cnt_clr = 1'b1;
    @(negedge clk); bit_en = 1'b0; cnt_clr = 1'b0;
    check("R10 clear beats increment", loss_cnt, 0);
    send_byte(8'hFF); send_payload();
    check("R8 counting resumes", loss_cnt, 1);

    // R6: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset again out_of_sync", out_of_sync, 1);
    check("R8 reset again loss_cnt", loss_cnt, 0);
    rst_n = 1'b1;

    finished = 1'b1;
    summary();
  end
endmodule